// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

This block is a memory-mapped interval timer with a 64-bit counter. Software reaches it over a simple 32-bit register bus with address, write enable, write data, read enable and read data. It programs a 64-bit period as two 32-bit words. It selects a clock divider and either continuous or one-shot operation. It then starts the timer with a strobe. While the timer is running, the counter steps once per divided clock tick. When the counter equals the period on a tick, it returns to zero and a one-cycle `period_done` pulse follows.

Software reads the count as two words. It reads the low word first. That read also captures the high word into a shadow register, so the next high-word read gives a coherent 64-bit value even if a carry happens between the two reads. Loading all-ones into both period words gives a free-running 64-bit counter. A self-clearing software reset returns the block to a stopped, zeroed state so that it can be programmed again.

Top module: `pit64_timer`

## Requirements
- R1: After `rst_n` is released, every register reads zero and `period_done` is low.
- R2: Writing 1 to control bit 0 (offset 0x00) starts the timer. While the timer runs, the counter rises by one on each tick. With divider 0 the first tick comes on the clock after the start write, so the count sampled k clocks after the start write is k.
- R3: Mode bits 11:8 (offset 0x04) hold a divider value N. A running timer makes one tick every N+1 clocks, and the count holds between ticks.
- R4: With mode bit 0 set (continuous), a tick that finds the count equal to the period sets the count to 0. `period_done` is then high for exactly the one following clock.
- R5: With mode bit 0 clear (one-shot), the same event also stops the timer. The count stays 0 and the running bit reads 0. A count equal to the period has not yet stopped the timer.
- R6: Writing 1 to control bit 8 clears the count, the divider phase, the running flag, the mode word, both period words and the count shadow. In the same write, this reset takes priority over a start.
- R7: The period low word is at 0x08 and the high word at 0x0C, and both read back as written. All-ones in both words makes the count run freely.
- R8: The count low word is read at 0x20 and the high word at 0x24. A low-word read captures the high half into a shadow register, and a high-word read returns that shadow. Read data appears on the clock after the read enable and holds until the next read.
- R9: Reads of unmapped offsets return 0. A control-word read returns the running flag in bit 0, with the other bits zero. A mode-word read returns the divider in bits 11:8 and the mode in bit 0.
- R10: Writes to the mode or period words take effect on the next clock, even while the timer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| period_done | output | 1 | One-cycle pulse after each period match |

## Verification
The count is sampled after a known number of clocks for several divider values: 0, 1, 2, 3 and 15. This separates a correct divide-by-N+1 from an off-by-one phase. It is checked with free-running all-ones periods and with small periods in continuous mode, which shows the wrap arithmetic. It is also checked in one-shot mode on both sides of the stop point, which shows that a count equal to the period still runs and the next match stops the timer. Directed cases cover the following:
- the pulse count over a window and the width of one pulse;
- period and divider changes while the timer is running;
- a reset write that also carries a start;
- reads of unmapped offsets.

// File: rtl/pit64_pkg.sv
package pit64_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 2 * WORD_W;
  localparam int PSC_W  = 4;
  localparam int BYTES_PER_WORD = WORD_W / 8;

  // register byte offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_MODE   = 'h04;
  localparam int OFS_PER_LO = 'h08;
  localparam int OFS_CNT_LO = 'h20;
  localparam int OFS_CNT_HI = OFS_CNT_LO + BYTES_PER_WORD;

  // bit positions
  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_RST_BIT   = 8;
  localparam int CTRL_RUN_BIT   = 0;
  localparam int MODE_CONT_BIT  = 0;
  localparam int MODE_DIV_LSB   = 8;

  // tick is due once the phase has reached the divider value
  function automatic logic tick_due(input logic [PSC_W-1:0] phase,
                                    input logic [PSC_W-1:0] divv);
    return phase >= divv;
  endfunction

  function automatic logic [PSC_W-1:0] next_phase(input logic [PSC_W-1:0] phase,
                                                  input logic due);
    return due ? '0 : phase + 1'b1;
  endfunction

  function automatic logic at_period(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] period);
    return cnt == period;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic wrap);
    return wrap ? '0 : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/pit64_prescaler.sv
module pit64_prescaler
  import pit64_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic             sw_rst_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] phase_q;
  logic             due;

  assign due    = tick_due(phase_q, div_i);
  assign tick_o = running_i && due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase_q <= '0;
    else if (sw_rst_i || !running_i) phase_q <= '0;
    else                            phase_q <= next_phase(phase_q, due);
  end

  // R3: after a tick the divider phase restarts from zero
  assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (phase_q == '0))
    else $error("phase did not restart after tick");

  // R3: a stopped timer keeps the phase at zero
  assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !running_i |=> (phase_q == '0))
    else $error("phase moved while stopped");
endmodule

// File: rtl/pit64_counter.sv
module pit64_counter
  import pit64_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             sw_rst_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             wrap_o,
  output logic             period_done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;
  logic             wrap_evt;
  logic             oneshot_end;

  assign wrap_evt    = tick_i && at_period(cnt_q, period_i);
  assign oneshot_end = wrap_evt && !cont_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sw_rst_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= next_count(cnt_q, wrap_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= 1'b0;
    else if (sw_rst_i)    run_q <= 1'b0;
    else if (oneshot_end) run_q <= 1'b0;
    else if (start_i)     run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (sw_rst_i) done_q <= 1'b0;
    else               done_q <= wrap_evt;
  end

  assign cnt_o         = cnt_q;
  assign running_o     = run_q;
  assign wrap_o        = wrap_evt;
  assign period_done_o = done_q;

  // R4: a period match returns the count to zero
  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0))
    else $error("count not zero after wrap");

  // R4: the done pulse lasts a single cycle while the period is nonzero
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_done_o && period_i != '0) |-> !wrap_o)
    else $error("back-to-back done with nonzero period");

  // R5: a one-shot match stops the timer
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !cont_i) |=> !running_o)
    else $error("one-shot did not stop");

  // R3: the count holds between ticks
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !sw_rst_i) |=> $stable(cnt_o))
    else $error("count moved without tick");

  // R6: software reset leaves a stopped, cleared counter
  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> (cnt_o == '0 && !running_o && !period_done_o))
    else $error("soft reset incomplete");
endmodule

// File: rtl/pit64_regs.sv
module pit64_regs
  import pit64_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              running_i,
  output logic              start_o,
  output logic              sw_rst_o,
  output logic [PSC_W-1:0]  div_o,
  output logic              cont_o,
  output logic [CNT_W-1:0]  period_o
);
  localparam int N_WORDS = CNT_W / WORD_W;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);

  logic               sel_ctrl, sel_mode, sel_cnt_lo, sel_cnt_hi;
  logic [N_WORDS-1:0] sel_per;
  logic               unmapped;
  logic [WORD_W-1:0]  shadow_q;
  logic [WORD_W-1:0]  rd_next;
  logic [WORD_W-1:0]  rdata_q;
  logic [PSC_W-1:0]   div_q;
  logic               cont_q;

  assign sel_ctrl   = bus_addr == A_CTRL;
  assign sel_mode   = bus_addr == A_MODE;
  assign sel_cnt_lo = bus_addr == A_CNT_LO;
  assign sel_cnt_hi = bus_addr == A_CNT_HI;
  assign unmapped   = !(sel_ctrl || sel_mode || sel_cnt_lo || sel_cnt_hi || (|sel_per));

  // control strobes: reset wins over start
  assign sw_rst_o = bus_we && sel_ctrl && bus_wdata[CTRL_RST_BIT];
  assign start_o  = bus_we && sel_ctrl && bus_wdata[CTRL_START_BIT] && !bus_wdata[CTRL_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cont_q <= 1'b0;
    end else if (sw_rst_o) begin
      div_q  <= '0;
      cont_q <= 1'b0;
    end else if (bus_we && sel_mode) begin
      div_q  <= bus_wdata[MODE_DIV_LSB +: PSC_W];
      cont_q <= bus_wdata[MODE_CONT_BIT];
    end
  end

  assign div_o  = div_q;
  assign cont_o = cont_q;

  // one register per period word
  for (genvar w = 0; w < N_WORDS; w++) begin : g_per
    logic [WORD_W-1:0] word_q;
    assign sel_per[w] = bus_addr == ADDR_W'(OFS_PER_LO + w * BYTES_PER_WORD);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      word_q <= '0;
      else if (sw_rst_o)               word_q <= '0;
      else if (bus_we && sel_per[w])   word_q <= bus_wdata;
    end
    assign period_o[w*WORD_W +: WORD_W] = word_q;
  end

  // read mux
  always_comb begin
    rd_next = '0;
    if (sel_ctrl)        rd_next[CTRL_RUN_BIT] = running_i;
    else if (sel_mode) begin
      rd_next[MODE_DIV_LSB +: PSC_W] = div_q;
      rd_next[MODE_CONT_BIT]         = cont_q;
    end
    else if (sel_cnt_lo) rd_next = cnt_i[WORD_W-1:0];
    else if (sel_cnt_hi) rd_next = shadow_q;
    else begin
      for (int w = 0; w < N_WORDS; w++)
        if (sel_per[w]) rd_next = period_o[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    shadow_q <= '0;
    else if (sw_rst_o)             shadow_q <= '0;
    else if (bus_re && sel_cnt_lo) shadow_q <= cnt_i[CNT_W-1:WORD_W];
  end

  assign bus_rdata = rdata_q;

  // R8: low-word read captures the high half
  assert_shadow_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel_cnt_lo && !sw_rst_o) |=> (shadow_q == $past(cnt_i[CNT_W-1:WORD_W])))
    else $error("shadow capture mismatch");

  // R8: high-word read returns the shadow
  assert_high_from_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel_cnt_hi) |=> (bus_rdata == $past(shadow_q)))
    else $error("high word not from shadow");

  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && unmapped) |=> (bus_rdata == '0))
    else $error("unmapped read nonzero");

  // R8: read data holds without a read
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata))
    else $error("read data changed without read");

  // R10: a mode write is visible on the next clock
  assert_mode_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_mode) |=> (div_o == $past(bus_wdata[MODE_DIV_LSB +: PSC_W])))
    else $error("mode write not applied");
endmodule

// File: rtl/pit64_timer.sv
module pit64_timer
  import pit64_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              period_done
);
  logic             start_s, sw_rst_s, cont_s, tick_s, running_s, wrap_s;
  logic [PSC_W-1:0] div_s;
  logic [CNT_W-1:0] period_s, cnt_s;

  pit64_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .cnt_i     (cnt_s),
    .running_i (running_s),
    .start_o   (start_s),
    .sw_rst_o  (sw_rst_s),
    .div_o     (div_s),
    .cont_o    (cont_s),
    .period_o  (period_s)
  );

  pit64_prescaler u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .running_i (running_s),
    .sw_rst_i  (sw_rst_s),
    .div_i     (div_s),
    .tick_o    (tick_s)
  );

  pit64_counter u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_s),
    .start_i       (start_s),
    .sw_rst_i      (sw_rst_s),
    .cont_i        (cont_s),
    .period_i      (period_s),
    .cnt_o         (cnt_s),
    .running_o     (running_s),
    .wrap_o        (wrap_s),
    .period_done_o (period_done)
  );

  // R4: the done pulse follows a period match by one clock
  assert_done_follows_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_s && !sw_rst_s) |=> period_done)
    else $error("missing done pulse");

  // R2: ticks only occur while running
  assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running_s |=> $stable(cnt_s) || $past(sw_rst_s))
    else $error("count moved while stopped");
endmodule

// File: tb/pit64_timer_bench.sv
module pit64_timer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  divv;
    logic        cont;
    logic [63:0] period;
    logic [15:0] wait_cyc;
    logic [31:0] exp_lo;
    logic        exp_run;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  1'b1, ONES,   16'd20,  32'd20, 1'b1},  // R2 free run
    '{4'd15, 1'b1, ONES,   16'd100, 32'd6,  1'b1},  // R3 /16
    '{4'd3,  1'b1, ONES,   16'd37,  32'd9,  1'b1},  // R3 /4
    '{4'd0,  1'b1, 64'd4,  16'd23,  32'd3,  1'b1},  // R4 wrap
    '{4'd1,  1'b1, 64'd2,  16'd20,  32'd1,  1'b1},  // R4 wrap with divider
    '{4'd0,  1'b0, 64'd5,  16'd4,   32'd4,  1'b1},  // R5 before stop
    '{4'd0,  1'b0, 64'd5,  16'd30,  32'd0,  1'b0},  // R5 stopped
    '{4'd2,  1'b0, 64'd3,  16'd11,  32'd3,  1'b0},  // R5 at period then stop
    '{4'd1,  1'b0, 64'd3,  16'd6,   32'd3,  1'b1}   // R5 at period still running
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        period_done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int pulses = 0;
  bit done = 1'b0;

  pit64_timer u_pit64_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .period_done(period_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (period_done) pulses <= pulses + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic prog(input logic [3:0] dv, input logic ct, input logic [63:0] p);
    wr(8'h00, 32'h100);
    wr(8'h04, {20'd0, dv, 7'd0, ct});
    wr(8'h0C, p[63:32]);
    wr(8'h08, p[31:0]);
    wr(8'h00, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 done low", period_done, 0);
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 mode", d, 0);
    rd(8'h08, d); check("R1 period lo", d, 0);
    rd(8'h0C, d); check("R1 period hi", d, 0);
    rd(8'h20, d); check("R1 count lo", d, 0);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      prog(VECS[i].divv, VECS[i].cont, VECS[i].period);
      repeat (int'(VECS[i].wait_cyc)) @(negedge clk);
      rd(8'h20, d); check($sformatf("R2/R3 vec%0d count lo", i), d, VECS[i].exp_lo);
      rd(8'h00, d); check($sformatf("R5 vec%0d running", i), d, {31'd0, VECS[i].exp_run});
      rd(8'h24, d); check($sformatf("R8 vec%0d count hi", i), d, 0);
    end

    // R7 period readback and R9 mode readback
    prog(4'd7, 1'b1, 64'h0000_00C3_A5A5_1234);
    rd(8'h08, d); check("R7 period lo", d, 32'hA5A5_1234);
    rd(8'h0C, d); check("R7 period hi", d, 32'h0000_00C3);
    rd(8'h04, d); check("R9 mode readback", d, 32'h0000_0701);

    // R9 unmapped
    rd(8'h10, d); check("R9 unmapped 0x10", d, 0);
    rd(8'h2C, d); check("R9 unmapped 0x2C", d, 0);

    // R6 soft reset clears everything
    wr(8'h00, 32'h100);
    rd(8'h00, d); check("R6 ctrl", d, 0);
    rd(8'h04, d); check("R6 mode", d, 0);
    rd(8'h08, d); check("R6 period lo", d, 0);
    rd(8'h0C, d); check("R6 period hi", d, 0);
    rd(8'h20, d); check("R6 count", d, 0);

    // R6 reset beats start in the same write
    wr(8'h04, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h00, 32'h101);
    repeat (5) @(negedge clk);
    rd(8'h00, d); check("R6 reset over start running", d, 0);
    rd(8'h20, d); check("R6 reset over start count", d, 0);

    // R4 pulse width and count, continuous period 3
    prog(4'd0, 1'b1, 64'd3);
    p0 = pulses;
    repeat (4) @(negedge clk);
    check("R4 pulse high", period_done, 1);
    @(negedge clk);
    check("R4 pulse one cycle", period_done, 0);
    repeat (33) @(negedge clk);
    check("R4 pulse count", 64'(pulses - p0), 9);

    // R5 one-shot gives exactly one pulse
    prog(4'd0, 1'b0, 64'd2);
    p0 = pulses;
    repeat (20) @(negedge clk);
    check("R5 one pulse", 64'(pulses - p0), 1);

    // R10 period change while running
    prog(4'd0, 1'b1, 64'd1000);
    wr(8'h08, 32'd3);
    repeat (21) @(negedge clk);
    rd(8'h20, d); check("R10 live period", d, 2);

    // R10 divider change while running
    prog(4'd15, 1'b1, ONES);
    wr(8'h04, 32'h1);
    repeat (10) @(negedge clk);
    rd(8'h20, d); check("R10 live divider", d, 10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule